// File: doc/BRIEF.md
# Adaptive Dead-Time Delay Loop

This block is the digital memory and delay stage of a dead-time loop for one switching transition of a synchronous step-down power stage. Sensing logic outside the block judges each cycle whether the gate turned on too early or too late. It reports that judgement as an up or down pulse, qualified by an update strobe. The block keeps a small saturating code. Each strobe moves the code by at most one step, and the block uses the code to set how long the turn-on edge of the gate command waits.

The delay is counted in periods of a fast timing clock, and one period stands for one delay-cell step. The falling (turn-off) edge of the gate command passes straight through with no delay. A code step that arrives while a turn-on delay is counting is held back until that delay has finished. If the request is withdrawn early, the pending turn-on is dropped. Two instances are used in a converter: one delays the low-side turn-on after the high side turns off, and the other delays the high-side turn-on after the low side turns off. Each instance has its own code. In steady state the code dithers by one step around the point where the dead-time is shortest.

Top module: `dtc_loop`

## Requirements
- R1: Each rising clock edge that samples `upd_stb` high applies at most one step to `code`, changing it by exactly one. `code` never changes on an edge without a strobe, except for a held step (R7).
- R2: `up_pulse` and `dn_pulse` are read only while `upd_stb` is high. If both are high at that edge, the step is an increment.
- R3: The code saturates. An increment at all ones leaves the code at all ones, and a decrement at zero leaves it at zero.
- R4: Take the first clock edge that samples `gate_req` high after it was low. `gate_out` rises `BASE_TAPS + code` clock periods after that edge. A larger code always gives a longer delay.
- R5: `gate_out` is low in any cycle in which `gate_req` is low, with no clock edge needed. The turn-off edge is never delayed.
- R6: After reset, `gate_out` is low. `code` is 1 followed by zeros (8 for a 4-bit code) when `START_MAX` is 0, and all ones when `START_MAX` is 1.
- R7: A strobe sampled while a turn-on delay is counting does not change `code` during that delay. The step is held and applied at the clock edge after the one that raises `gate_out`. If several strobes arrive in one delay, only the last is kept.
- R8: A strobe sampled on the same edge that starts a delay is applied at once, but that delay still uses the code from before the step.
- R9: If `gate_req` falls before the delay expires, the pending turn-on is cancelled. `gate_out` stays low, and the next rise of `gate_req` starts a full new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock; one period is one delay tap |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_req | input | 1 | Undelayed gate command from the modulator |
| upd_stb | input | 1 | Qualifies the up/down decision for one cycle |
| up_pulse | input | 1 | Request for a longer delay |
| dn_pulse | input | 1 | Request for a shorter delay |
| gate_out | output | 1 | Gate command with the turn-on edge delayed |
| code | output | CODE_W | Current loop code |

## Verification
Two of the block's functions can fall in the same cycle: a code step and the start or run of a turn-on delay. The bench provokes this in two ways. It raises the request on the same edge as a down strobe, and it issues an up strobe one cycle after a delay has begun. In the first case it expects the delay length to follow the old code while the code output already shows the new one. In the second case it expects the code to stay frozen until the edge after the gate rises and only then to move by one.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

   // Increment wins when both requests are present.
   function automatic step_e pick_step(input logic stb, input logic up, input logic dn);
      if (!stb)     return STEP_HOLD;
      else if (up)  return STEP_UP;
      else if (dn)  return STEP_DOWN;
      else          return STEP_HOLD;
   endfunction

endpackage

// File: rtl/dtc_step_ctr.sv
module dtc_step_ctr
   import dtc_pkg::*;
#(
   parameter int CODE_W    = 4,
   parameter bit START_MAX = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  step_e             step_in,
   output logic [CODE_W-1:0] code
);

   localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};
   localparam logic [CODE_W-1:0] RST_CODE = START_MAX ? CODE_TOP : CODE_MID;

   logic  pend_v;
   step_e pend_s;
   step_e step_eff;

   function automatic logic [CODE_W-1:0] apply_step(input logic [CODE_W-1:0] c, input step_e s);
      case (s)
         STEP_UP:   return (c == CODE_TOP) ? c : c + 1'b1;
         STEP_DOWN: return (c == '0) ? c : c - 1'b1;
         default:   return c;
      endcase
   endfunction

   assign step_eff = pend_v ? pend_s : step_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code   <= RST_CODE;
         pend_v <= 1'b0;
         pend_s <= STEP_HOLD;
      end else if (hold) begin
         if (step_in != STEP_HOLD) begin
            pend_v <= 1'b1;
            pend_s <= step_in;
         end
      end else begin
         code <= apply_step(code, step_eff);
         if (pend_v) begin
            pend_v <= (step_in != STEP_HOLD);
            pend_s <= step_in;
         end
      end
   end

endmodule

// File: rtl/dtc_edge_delay.sv
module dtc_edge_delay #(
   parameter int CODE_W    = 4,
   parameter int BASE_TAPS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [CODE_W-1:0] code,
   output logic              gate_out,
   output logic              busy
);

   localparam int TAP_MAX = BASE_TAPS + (1 << CODE_W) - 1;
   localparam int TAP_W   = $clog2(TAP_MAX + 1);

   logic             req_q;
   logic             on_q;
   logic [TAP_W-1:0] cnt;
   logic             start;

   assign start = req & ~req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         on_q  <= 1'b0;
         busy  <= 1'b0;
         cnt   <= '0;
      end else begin
         req_q <= req;
         if (!req) begin
            busy <= 1'b0;
            on_q <= 1'b0;
         end else if (start) begin
            busy <= 1'b1;
            cnt  <= TAP_W'(BASE_TAPS) + TAP_W'(code);
         end else if (busy) begin
            if (cnt == TAP_W'(1)) begin
               busy <= 1'b0;
               on_q <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // Turn-off is combinational from the request: no added delay.
   assign gate_out = req & on_q;

endmodule

// File: rtl/dtc_loop.sv
module dtc_loop
   import dtc_pkg::*;
#(
   parameter int CODE_W    = 4,
   parameter int BASE_TAPS = 1,
   parameter bit START_MAX = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_req,
   input  logic              upd_stb,
   input  logic              up_pulse,
   input  logic              dn_pulse,
   output logic              gate_out,
   output logic [CODE_W-1:0] code
);

   generate
      if (CODE_W < 2 || CODE_W > 8) begin : g_bad_width
         $error("dtc_loop: CODE_W must be in 2..8");
      end
      if (BASE_TAPS < 1) begin : g_bad_base
         $error("dtc_loop: BASE_TAPS must be at least 1");
      end
   endgenerate

   step_e step_now;
   logic  dly_busy;

   assign step_now = pick_step(upd_stb, up_pulse, dn_pulse);

   dtc_step_ctr #(
      .CODE_W    (CODE_W),
      .START_MAX (START_MAX)
   ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (dly_busy),
      .step_in (step_now),
      .code    (code)
   );

   dtc_edge_delay #(
      .CODE_W    (CODE_W),
      .BASE_TAPS (BASE_TAPS)
   ) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (gate_req),
      .code     (code),
      .gate_out (gate_out),
      .busy     (dly_busy)
   );

endmodule

// File: rtl/dtc_loop_chk.sv
module dtc_loop_chk #(
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gate_req,
   input logic              gate_out,
   input logic              busy,
   input logic [CODE_W-1:0] code
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (code != $past(code)) |-> ((code == CODE_W'($past(code) + 1'b1)) || (code == CODE_W'($past(code) - 1'b1)))); // R1

   AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(code) == {CODE_W{1'b1}}) |-> (code != '0)); // R3

   AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(code) == '0) |-> (code != {CODE_W{1'b1}})); // R3

   AST_FALL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_req |-> !gate_out); // R5

   AST_RISE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $rose(gate_out) |-> $past(gate_req)); // R4

   AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(busy) |-> $stable(code)); // R7

endmodule

bind dtc_loop dtc_loop_chk #(.CODE_W(CODE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .gate_req (gate_req),
   .gate_out (gate_out),
   .busy     (dly_busy),
   .code     (code)
);

// File: tb/tb_dtc_loop.sv
module tb_dtc_loop;

   localparam int CLK_PERIOD = 10;
   localparam int CODE_W     = 4;
   localparam int BASE_TAPS  = 1;
   localparam int CODE_MAX   = (1 << CODE_W) - 1;

   logic clk = 1'b0;
   logic rst_n;
   logic gate_req, upd_stb, up_pulse, dn_pulse;
   logic gate_out, gate_out_max;
   logic [CODE_W-1:0] code, code_max;

   int errors = 0;
   int checks = 0;
   int model  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dtc_loop #(.CODE_W(CODE_W), .BASE_TAPS(BASE_TAPS), .START_MAX(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .gate_req(gate_req), .upd_stb(upd_stb),
      .up_pulse(up_pulse), .dn_pulse(dn_pulse), .gate_out(gate_out), .code(code));

   dtc_loop #(.CODE_W(CODE_W), .BASE_TAPS(BASE_TAPS), .START_MAX(1'b1)) dut_max (
      .clk(clk), .rst_n(rst_n), .gate_req(gate_req), .upd_stb(upd_stb),
      .up_pulse(up_pulse), .dn_pulse(dn_pulse), .gate_out(gate_out_max), .code(code_max));

   function automatic int next_code(input int c, input bit u, input bit d);
      if (u)      return (c == CODE_MAX) ? c : c + 1;
      else if (d) return (c == 0) ? c : c - 1;
      else        return c;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_step(input bit s, input bit u, input bit d, input string req);
      upd_stb = s; up_pulse = u; dn_pulse = d;
      tick();
      upd_stb = 0; up_pulse = 0; dn_pulse = 0;
      if (s) model = next_code(model, u, d);
      chk(int'(code) == model, req, int'(code), model);
   endtask

   task automatic set_code(input int target);
      while (model < target) do_step(1, 1, 0, "R1");
      while (model > target) do_step(1, 0, 1, "R1");
   endtask

   task automatic measure(input string req);
      int d;
      d = BASE_TAPS + model;
      gate_req = 1;
      for (int k = 1; k <= d + 2; k++) begin
         tick();
         chk(gate_out == (k >= d + 1), req, int'(gate_out), int'(k >= d + 1));
      end
      gate_req = 0;
      #1;
      chk(gate_out == 1'b0, "R5", int'(gate_out), 0);
      tick();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int d;
      void'($urandom(32'd2024));
      rst_n = 0; gate_req = 0; upd_stb = 0; up_pulse = 0; dn_pulse = 0;
      repeat (3) tick();
      // R6: reset values of both start options
      chk(int'(code) == 8, "R6", int'(code), 8);
      chk(int'(code_max) == CODE_MAX, "R6", int'(code_max), CODE_MAX);
      chk(gate_out == 1'b0, "R6", int'(gate_out), 0);
      rst_n = 1;
      model = 8;
      tick();

      // R2: both requests -> increment
      do_step(1, 1, 1, "R2");
      // R2: pulses ignored without strobe
      do_step(0, 1, 0, "R2");
      do_step(0, 0, 1, "R2");
      // R3: saturation at top, also with both requests
      set_code(CODE_MAX);
      do_step(1, 1, 0, "R3");
      do_step(1, 1, 1, "R3");
      // R3: saturation at bottom
      set_code(0);
      do_step(1, 0, 1, "R3");
      // R1: dithering around a point
      set_code(6);
      for (int i = 0; i < 6; i++) do_step(1, (i % 2) == 0, (i % 2) == 1, "R1");

      // R1/R2/R3: random walk with drifting bias
      for (int i = 0; i < 400; i++) begin
         bit s, u, dn;
         s  = ($urandom % 100) < 70;
         u  = ($urandom % 100) < (((i / 50) % 2) == 0 ? 80 : 20);
         dn = $urandom % 2;
         do_step(s, u, dn, "R1");
      end

      // R4: delay at fixed and random codes
      set_code(0);          measure("R4");
      set_code(5);          measure("R4");
      set_code(CODE_MAX);   measure("R4");
      for (int i = 0; i < 6; i++) begin
         set_code($urandom % (CODE_MAX + 1));
         measure("R4");
      end

      // R7: strobe during a running delay is held
      set_code(4);
      d = BASE_TAPS + model;
      gate_req = 1;
      tick();
      upd_stb = 1; up_pulse = 1;
      tick();
      upd_stb = 0; up_pulse = 0;
      for (int k = 3; k <= d + 2; k++) begin
         tick();
         if (k <= d + 1) chk(int'(code) == 4, "R7", int'(code), 4);
         else            chk(int'(code) == 5, "R7", int'(code), 5);
         chk(gate_out == (k >= d + 1), "R7", int'(gate_out), int'(k >= d + 1));
      end
      model = 5;
      gate_req = 0;
      tick();

      // R8: strobe on the start edge; delay uses old code
      d = BASE_TAPS + model;
      gate_req = 1; upd_stb = 1; dn_pulse = 1;
      for (int k = 1; k <= d + 2; k++) begin
         tick();
         upd_stb = 0; dn_pulse = 0;
         if (k == 1) chk(int'(code) == 4, "R8", int'(code), 4);
         chk(gate_out == (k >= d + 1), "R8", int'(gate_out), int'(k >= d + 1));
      end
      model = 4;
      gate_req = 0;
      tick();

      // R9: early withdrawal cancels turn-on
      gate_req = 1;
      tick(); tick();
      gate_req = 0;
      for (int k = 0; k < BASE_TAPS + model + 3; k++) begin
         tick();
         chk(gate_out == 1'b0, "R9", int'(gate_out), 0);
      end
      chk(int'(code) == model, "R9", int'(code), model);
      measure("R9");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule